// File: doc/BRIEF.md
# L1 Link Power Entry and Exit Handshake

This block negotiates when a serial link may drop into its deep idle state, where both directions are quiet, and brings it back out again. One instance sits at each end of the link. A role input selects its behaviour. As the requesting (downstream) end, it sends a low-power request packet, repeats it at a programmable spacing, and stops once the peer answers. As the answering (upstream) end, it accepts the request only when it has no transmit traffic waiting, and rejects it otherwise.

Once an accept has been exchanged, the end sends one electrical-idle ordered set. It then waits for the peer's line to go idle before it turns off its own transmitter. The link leaves the idle state through a retraining phase. This phase starts on a wake event or when the peer leaves idle. It ends when training sets are received, and a watchdog flags every window that passes without them.

Packet framing and CRC are handled elsewhere, and so are the physical training details and clock gating. Here they appear only as one-cycle send and receive strobes and as level signals for idle and training.

Top module: `l1_link_pm`

## Requirements
- R1: While reset is held and in the first cycle after it, linkState is 0 (active), and txReq, txAck, txNak, txEios, txEidle, txTs and recovErr are all 0.
- R2: A requester (isRequester=1) with L1 allowed (aspmCtl equal to 2'b10 or 2'b11) that sees enterReq in the active state moves to linkState 1 (requesting) and pulses txReq in its first cycle there.
- R3: While requesting with no answer, txReq pulses exactly every retryGap cycles (a retryGap of 0 behaves as 1).
- R4: After MAX_TRIES requests with no answer, the requester returns to linkState 0, retryGap cycles after the last request, and sends no further request.
- R5: rxNak while requesting returns the block to linkState 0, and no further txReq follows.
- R6: rxAck while requesting moves the block to linkState 2, where txEios pulses for exactly one cycle, and then to linkState 3 (waiting for the peer's idle).
- R7: txEidle is high only in linkState 4 (L1). That state is entered from linkState 3 only once rxEidle is high.
- R8: A responder (isRequester=0) in the active state with L1 allowed and txPending=0 answers rxReq with txAck in the same cycle and moves to linkState 2.
- R9: A responder that receives rxReq while txPending=1, or while aspmCtl is 2'b00 or 2'b01, answers with txNak in the same cycle and stays in linkState 0.
- R10: When aspmCtl is 2'b00 or 2'b01, enterReq on a requester is ignored: linkState stays 0 and no txReq is sent.
- R11: In linkState 4, a wakeEvt pulse or rxEidle going low moves the block to linkState 5 (retraining), where txTs is high and txEidle is low.
- R12: rxTsOk in linkState 5 returns the block to linkState 0.
- R13: Without rxTsOk, recovErr pulses in the RECOV_CYC-th cycle of retraining and again every RECOV_CYC cycles after that, while the block stays in linkState 5.
- R14: At most one of txReq, txAck, txNak and txEios is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| isRequester | input | 1 | 1 = downstream requesting role, 0 = upstream answering role |
| aspmCtl | input | 2 | Power control field; L1 is allowed for 2'b10 and 2'b11 |
| enterReq | input | 1 | Local request to start L1 entry (requester role) |
| txPending | input | 1 | Local transmit traffic is waiting (responder role) |
| rxReq | input | 1 | Strobe: L1 request packet received |
| rxAck | input | 1 | Strobe: accept packet received |
| rxNak | input | 1 | Strobe: reject packet received |
| rxEidle | input | 1 | Peer's line detected electrically idle |
| wakeEvt | input | 1 | Wake, power-event or clock-request change |
| rxTsOk | input | 1 | Training sets received during retraining |
| retryGap | input | GAP_W | Cycles between repeated requests |
| txReq | output | 1 | Strobe: send L1 request packet |
| txAck | output | 1 | Strobe: send accept packet |
| txNak | output | 1 | Strobe: send reject packet |
| txEios | output | 1 | Strobe: send electrical-idle ordered set |
| txEidle | output | 1 | Hold own transmitter electrically idle |
| txTs | output | 1 | Send training sets |
| recovErr | output | 1 | Strobe: retraining window expired without training sets |
| linkState | output | 3 | 0 active, 1 requesting, 2 idle-set send, 3 wait peer idle, 4 L1, 5 retraining |

## Verification
The bench counts request spacing cycle by cycle against retryGap. An off-by-one reload in the gap counter would move every pulse, and a wrong try count would send one request too many or too few before giving up. It holds rxEidle low after the accept to show that a block which idles its transmitter too early leaves state 3 at once. It walks every control-field encoding against pending traffic on the answering side, which exposes an accept sent while data is queued or with L1 disallowed. It lets retraining run through two full windows, so a watchdog that fires a cycle late, or that does not rearm, shows up as a misplaced or missing recovErr.

// File: rtl/l1hs_pkg.sv
package l1hs_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE   = 3'd0,
    ST_REQWAIT  = 3'd1,
    ST_EIOS     = 3'd2,
    ST_WAITIDLE = 3'd3,
    ST_L1       = 3'd4,
    ST_RECOV    = 3'd5
  } linkSt_t;

  // control -> datapath strobes
  typedef struct packed {
    logic gapClr;
    logic gapReload;
    logic tryClr;
    logic recovClr;
    logic recovRun;
  } dpCmd_t;

  // datapath -> control flags
  typedef struct packed {
    logic gapExpired;
    logic triesDone;
    logic recovTimeout;
  } dpStat_t;

endpackage

// File: rtl/l1hs_dpath.sv
module l1hs_dpath
  import l1hs_pkg::*;
#(
  parameter int GAP_W     = 16,
  parameter int MAX_TRIES = 8,
  parameter int RECOV_CYC = 6400
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [GAP_W-1:0] retryGap,
  input  dpCmd_t           cmd,
  output dpStat_t          stat
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam int REC_W = $clog2(RECOV_CYC);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRIES);
  localparam logic [REC_W-1:0] REC_LAST = REC_W'(RECOV_CYC - 1);

  logic [GAP_W-1:0] gapCnt;
  logic [TRY_W-1:0] tryCnt;
  logic [REC_W-1:0] recovCnt;
  logic [GAP_W-1:0] gapReloadVal;

  assign gapReloadVal = (retryGap == '0) ? '0 : retryGap - GAP_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (cmd.gapClr) begin
      gapCnt <= '0;
    end else if (cmd.gapReload) begin
      gapCnt <= gapReloadVal;
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tryCnt <= '0;
    end else if (cmd.tryClr) begin
      tryCnt <= '0;
    end else if (cmd.gapReload && tryCnt != TRY_LAST) begin
      tryCnt <= tryCnt + TRY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recovCnt <= '0;
    end else if (cmd.recovClr) begin
      recovCnt <= '0;
    end else if (cmd.recovRun) begin
      recovCnt <= recovCnt + REC_W'(1);
    end
  end

  assign stat.gapExpired   = (gapCnt == '0);
  assign stat.triesDone    = (tryCnt == TRY_LAST);
  assign stat.recovTimeout = (recovCnt == REC_LAST);

  // R4
  try_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    tryCnt <= TRY_LAST);

  // R13
  recov_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.recovRun && !cmd.recovClr) |=> recovCnt != '0);

endmodule

// File: rtl/l1hs_ctrl.sv
module l1hs_ctrl
  import l1hs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    isRequester,
  input  logic    l1En,
  input  logic    enterReq,
  input  logic    txPending,
  input  logic    rxReq,
  input  logic    rxAck,
  input  logic    rxNak,
  input  logic    rxEidle,
  input  logic    wakeEvt,
  input  logic    rxTsOk,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output linkSt_t state,
  output logic    txReq,
  output logic    txAck,
  output logic    txNak,
  output logic    txEios,
  output logic    txEidle,
  output logic    txTs,
  output logic    recovErr
);
  linkSt_t stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= stNext;
  end

  always_comb begin
    stNext   = state;
    cmd      = '0;
    txReq    = 1'b0;
    txAck    = 1'b0;
    txNak    = 1'b0;
    txEios   = 1'b0;
    txEidle  = 1'b0;
    txTs     = 1'b0;
    recovErr = 1'b0;
    unique case (state)
      ST_ACTIVE: begin
        if (isRequester) begin
          if (enterReq && l1En) begin
            stNext     = ST_REQWAIT;
            cmd.gapClr = 1'b1;
            cmd.tryClr = 1'b1;
          end
        end else if (rxReq) begin
          if (l1En && !txPending) begin
            txAck  = 1'b1;
            stNext = ST_EIOS;
          end else begin
            txNak = 1'b1;
          end
        end
      end
      ST_REQWAIT: begin
        if (rxAck) begin
          stNext = ST_EIOS;
        end else if (rxNak) begin
          stNext = ST_ACTIVE;
        end else if (stat.gapExpired) begin
          if (stat.triesDone) begin
            stNext = ST_ACTIVE;
          end else begin
            txReq         = 1'b1;
            cmd.gapReload = 1'b1;
          end
        end
      end
      ST_EIOS: begin
        txEios = 1'b1;
        stNext = ST_WAITIDLE;
      end
      ST_WAITIDLE: begin
        if (rxEidle) stNext = ST_L1;
      end
      ST_L1: begin
        txEidle = 1'b1;
        if (wakeEvt || !rxEidle) begin
          stNext       = ST_RECOV;
          cmd.recovClr = 1'b1;
        end
      end
      ST_RECOV: begin
        txTs = 1'b1;
        if (rxTsOk) begin
          stNext = ST_ACTIVE;
        end else begin
          cmd.recovRun = 1'b1;
          if (stat.recovTimeout) begin
            recovErr     = 1'b1;
            cmd.recovClr = 1'b1;
          end
        end
      end
      default: stNext = ST_ACTIVE;
    endcase
  end

  // R14
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txReq, txAck, txNak, txEios}));

  // R7
  idle_after_peer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_L1 && $past(state) == ST_WAITIDLE) |-> $past(rxEidle));

  // R11
  l1_exit_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_L1 && state != ST_L1) |-> state == ST_RECOV);

  // R6
  eios_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    txEios |=> !txEios);

  // R8
  ack_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    txAck |=> state == ST_EIOS);

endmodule

// File: rtl/l1_link_pm.sv
module l1_link_pm
  import l1hs_pkg::*;
#(
  parameter int GAP_W     = 16,
  parameter int MAX_TRIES = 8,
  parameter int RECOV_CYC = 6400
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             isRequester,
  input  logic [1:0]       aspmCtl,
  input  logic             enterReq,
  input  logic             txPending,
  input  logic             rxReq,
  input  logic             rxAck,
  input  logic             rxNak,
  input  logic             rxEidle,
  input  logic             wakeEvt,
  input  logic             rxTsOk,
  input  logic [GAP_W-1:0] retryGap,
  output logic             txReq,
  output logic             txAck,
  output logic             txNak,
  output logic             txEios,
  output logic             txEidle,
  output logic             txTs,
  output logic             recovErr,
  output logic [2:0]       linkState
);
  dpCmd_t  cmd;
  dpStat_t stat;
  linkSt_t state;
  logic    l1En;

  assign l1En      = (aspmCtl == 2'b10) || (aspmCtl == 2'b11);
  assign linkState = state;

  l1hs_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .isRequester(isRequester), .l1En(l1En),
    .enterReq(enterReq), .txPending(txPending), .rxReq(rxReq),
    .rxAck(rxAck), .rxNak(rxNak), .rxEidle(rxEidle), .wakeEvt(wakeEvt),
    .rxTsOk(rxTsOk), .stat(stat), .cmd(cmd), .state(state),
    .txReq(txReq), .txAck(txAck), .txNak(txNak), .txEios(txEios),
    .txEidle(txEidle), .txTs(txTs), .recovErr(recovErr)
  );

  l1hs_dpath #(
    .GAP_W(GAP_W), .MAX_TRIES(MAX_TRIES), .RECOV_CYC(RECOV_CYC)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .retryGap(retryGap), .cmd(cmd), .stat(stat)
  );

endmodule

// File: tb/l1_link_pm_tb.sv
`timescale 1ns/1ps
module l1_link_pm_tb_top;
  localparam int GAP_W = 16;
  localparam int TRIES = 4;
  localparam int RCYC  = 40;
  localparam int GAP   = 5;

  logic clk = 1'b0;
  logic rstN, isRequester, enterReq, txPending, rxReq, rxAck, rxNak;
  logic rxEidle, wakeEvt, rxTsOk;
  logic [1:0] aspmCtl;
  logic [GAP_W-1:0] retryGap;
  logic txReq, txAck, txNak, txEios, txEidle, txTs, recovErr;
  logic [2:0] linkState;

  int errCnt = 0;
  int chkCnt = 0;
  int overlapCnt = 0;

  always #2.5 clk = ~clk;

  l1_link_pm #(.GAP_W(GAP_W), .MAX_TRIES(TRIES), .RECOV_CYC(RCYC)) dut_i (
    .clk(clk), .rstN(rstN), .isRequester(isRequester), .aspmCtl(aspmCtl),
    .enterReq(enterReq), .txPending(txPending), .rxReq(rxReq),
    .rxAck(rxAck), .rxNak(rxNak), .rxEidle(rxEidle), .wakeEvt(wakeEvt),
    .rxTsOk(rxTsOk), .retryGap(retryGap), .txReq(txReq), .txAck(txAck),
    .txNak(txNak), .txEios(txEios), .txEidle(txEidle), .txTs(txTs),
    .recovErr(recovErr), .linkState(linkState)
  );

  // responder table: {aspmCtl[1:0], txPending, expAck, expNak, expState[2:0]}
  localparam logic [7:0] RESP_TBL [8] = '{
    {2'b00, 1'b0, 1'b0, 1'b1, 3'd0},
    {2'b00, 1'b1, 1'b0, 1'b1, 3'd0},
    {2'b01, 1'b0, 1'b0, 1'b1, 3'd0},
    {2'b01, 1'b1, 1'b0, 1'b1, 3'd0},
    {2'b10, 1'b0, 1'b1, 1'b0, 3'd2},
    {2'b10, 1'b1, 1'b0, 1'b1, 3'd0},
    {2'b11, 1'b0, 1'b1, 1'b0, 3'd2},
    {2'b11, 1'b1, 1'b0, 1'b1, 3'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic finishRun;
    $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  endtask

  task automatic doReset;
    rstN = 1'b0; isRequester = 1'b0; aspmCtl = 2'b00; enterReq = 1'b0;
    txPending = 1'b0; rxReq = 1'b0; rxAck = 1'b0; rxNak = 1'b0;
    rxEidle = 1'b0; wakeEvt = 1'b0; rxTsOk = 1'b0; retryGap = GAP_W'(GAP);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // sample one cycle into the negedge, after inputs settle
  task automatic step;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    #1;
    if (rstN && ($countones({txReq, txAck, txNak, txEios}) > 1)) overlapCnt++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1 reset state
    rstN = 1'b0;
    doReset();
    rstN = 1'b0;
    #1;
    chkEq("R1 state in reset", linkState, 0);
    chkEq("R1 outputs in reset",
          {txReq, txAck, txNak, txEios, txEidle, txTs, recovErr}, 0);
    rstN = 1'b1;
    step(); #1;
    chkEq("R1 state after reset", linkState, 0);
    chkEq("R1 outputs after reset",
          {txReq, txAck, txNak, txEios, txEidle, txTs, recovErr}, 0);

    // R8 / R9 responder table
    for (int i = 0; i < 8; i++) begin
      doReset();
      step();
      aspmCtl = RESP_TBL[i][7:6];
      txPending = RESP_TBL[i][5];
      rxReq = 1'b1;
      #1;
      chkEq($sformatf("R8/R9 txAck row %0d", i), txAck, RESP_TBL[i][4]);
      chkEq($sformatf("R8/R9 txNak row %0d", i), txNak, RESP_TBL[i][3]);
      step(); rxReq = 1'b0; #1;
      chkEq($sformatf("R8/R9 state row %0d", i), linkState, RESP_TBL[i][2:0]);
    end

    // R10 disabled requester
    doReset();
    step();
    isRequester = 1'b1; aspmCtl = 2'b01; enterReq = 1'b1;
    step(); enterReq = 1'b0;
    for (int k = 0; k < 6; k++) begin
      #1;
      chk(linkState == 0 && !txReq, "R10 enterReq ignored", {linkState, txReq}, 0);
      step();
    end

    // R2 R3 R4 request repetition and give-up
    doReset();
    step();
    isRequester = 1'b1; aspmCtl = 2'b10; enterReq = 1'b1;
    step(); enterReq = 1'b0; #1;
    chkEq("R2 requesting state", linkState, 1);
    chkEq("R2 first request", txReq, 1);
    for (int off = 1; off <= TRIES * GAP; off++) begin
      step(); #1;
      chkEq($sformatf("R3 txReq at offset %0d", off), txReq,
            ((off % GAP) == 0 && off < TRIES * GAP) ? 1 : 0);
    end
    chkEq("R4 still requesting at last expiry", linkState, 1);
    step(); #1;
    chkEq("R4 gave up to active", linkState, 0);
    chkEq("R4 no further request", txReq, 0);

    // R5 reject
    doReset();
    step();
    isRequester = 1'b1; aspmCtl = 2'b11; enterReq = 1'b1;
    step(); enterReq = 1'b0;
    step(); rxNak = 1'b1;
    step(); rxNak = 1'b0; #1;
    chkEq("R5 active after nak", linkState, 0);
    begin
      int seen = 0;
      for (int k = 0; k < 12; k++) begin
        #1; if (txReq) seen++;
        step();
      end
      chkEq("R5 no request after nak", seen, 0);
    end

    // R6 R7 R11 R12 accept, idle and wake exit
    doReset();
    step();
    isRequester = 1'b1; aspmCtl = 2'b10; enterReq = 1'b1;
    step(); enterReq = 1'b0;
    step(); rxAck = 1'b1; #1;
    chkEq("R6 no request with ack", txReq, 0);
    step(); rxAck = 1'b0; #1;
    chkEq("R6 eios state", linkState, 2);
    chkEq("R6 eios strobe", txEios, 1);
    step(); #1;
    chkEq("R6 wait idle state", linkState, 3);
    chkEq("R6 eios single cycle", txEios, 0);
    step(); step(); #1;
    chkEq("R7 waits for peer idle", linkState, 3);
    chkEq("R7 no idle before peer", txEidle, 0);
    rxEidle = 1'b1;
    step(); #1;
    chkEq("R7 in L1", linkState, 4);
    chkEq("R7 transmitter idle", txEidle, 1);
    step(); wakeEvt = 1'b1;
    step(); wakeEvt = 1'b0; #1;
    chkEq("R11 wake to retrain", linkState, 5);
    chk(txTs && !txEidle, "R11 training sets out", {txTs, txEidle}, 2);
    step(); step(); rxTsOk = 1'b1;
    step(); rxTsOk = 1'b0; #1;
    chkEq("R12 back to active", linkState, 0);

    // R11 R13 peer exit, retraining timeout
    doReset();
    step();
    isRequester = 1'b0; aspmCtl = 2'b11; rxReq = 1'b1;
    step(); rxReq = 1'b0; rxEidle = 1'b1;
    step(); step(); #1;
    chkEq("R7 responder in L1", linkState, 4);
    rxEidle = 1'b0;
    step(); #1;
    chkEq("R11 peer exit to retrain", linkState, 5);
    for (int off = 0; off < 2 * RCYC + 1; off++) begin
      chkEq($sformatf("R13 recovErr at offset %0d", off), recovErr,
            (off == RCYC - 1 || off == 2 * RCYC - 1) ? 1 : 0);
      step(); #1;
    end
    chkEq("R13 stays retraining", linkState, 5);
    rxTsOk = 1'b1;
    step(); rxTsOk = 1'b0; #1;
    chkEq("R12 active after training", linkState, 0);

    // R14 strobe exclusivity over the whole run
    chkEq("R14 overlapping strobes", overlapCnt, 0);

    finishRun();
  end
endmodule